// File: doc/BRIEF.md
# Key-Guarded Watchdog Timer

This block is a watchdog for a chip's reset system. It has a 32-bit register port and counts a slow reference clock of about 32 kHz. Software programs a timeout length and enables the countdown. It must then write a restart code at regular intervals. If it stops doing so, the count runs out and the block pulses a system reset request. A second, pin-level reset output follows that request, with the polarity software selects. An interrupt mode raises a sticky flag on expiry instead of resetting. In dual mode, the first expiry raises the flag and starts a new countdown, and the second expiry resets the chip. Separately from the countdown, software can request an immediate reset.

Each register guards itself against stray writes. A control write only takes effect when the write carries that register's key pattern, and the two action registers respond to one exact 32-bit code each. The timeout is counted in units. A prescaler divides the reference clock by 2^DIV_LOG2 cycles to form one unit, which with the default of 512 cycles is 1/64 s. A timeout of N seconds is therefore N×64 units.

Top module: `keyguard_wdt`

## Requirements
- R1: After bus reset, all registers are in their cleared state:
  - mode reads 0 and length reads 0;
  - `sys_rst_o` is 0 and `irq_o` is 0;
  - `ext_rst_o` is 1, which is the idle level for active-low polarity.
- R2: A write to offset 0x00 updates the mode only when data bits [31:24] equal 0x22. The stored bits are:
  - bit 0: run;
  - bit 1: external pin active-high;
  - bit 2: external pin enable;
  - bit 3: interrupt mode;
  - bit 4: auto-start (stored and read back only);
  - bit 6: dual mode.

  A read of offset 0x00 returns these bits in the same positions, with all other bits reading 0. A write with any other key leaves the mode unchanged.
- R3: A write to offset 0x04 updates the timeout length only when data bits [4:0] equal 0x08. The length field is data bits [15:5], and bits [31:16] are ignored. A read of offset 0x04 returns the length in bits [15:5] with zeros elsewhere. A write with any other key leaves the length unchanged.
- R4: Writing exactly 0x00001971 to offset 0x08 reloads the countdown from the stored length, restarts the unit prescaler and clears `irq_o`. Writing any other value to offset 0x08 has no effect on the expiry time.
- R5: The countdown is loaded from length L (L ≥ 1) by a reload or by an accepted mode write that sets run while run is 0. If no later reload occurs, the expiry takes effect on the clock edge L×2^DIV_LOG2 cycles after the loading edge.
- R6: While run is 0, the countdown and prescaler hold and no expiry occurs. Setting run again reloads the full length.
- R7: Writing exactly 0x00001209 to offset 0x14 starts a reset pulse on the next clock edge, whatever the mode.
- R8: An expiry in reset mode drives `sys_rst_o` high for exactly PULSE_LEN cycles. Further triggers that arrive during a pulse are absorbed. After one expiry, the countdown does not fire again until it is reloaded.
- R9: When the external pin enable is set, `ext_rst_o` equals `sys_rst_o` if the active-high bit is 1, and its inverse if the bit is 0. When the pin enable is clear, `ext_rst_o` rests at the inverse of the active-high bit.
- R10: In interrupt mode without dual mode, an expiry sets `irq_o` and produces no reset. `irq_o` stays set until a restart code or an enabling mode write.
- R11: In dual mode together with interrupt mode:
  - the first expiry sets `irq_o` and reloads the countdown;
  - an expiry while `irq_o` is set produces the reset pulse.
- R12: A newly written length does not change a countdown already in progress. It takes effect at the next reload or enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32 kHz reference clock; also clocks the register port |
| rst_n | input | 1 | Asynchronous bus reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| sys_rst_o | output | 1 | System reset request, active high |
| ext_rst_o | output | 1 | External reset pin with programmable polarity |
| irq_o | output | 1 | Sticky expiry interrupt flag |

## Verification
The assertions assume that `bus_wr` is a clean single-cycle strobe, sampled with `bus_addr` and `bus_wdata` on the same edge. They also assume the bus never holds a write across reset release. The bench drives every write as one strobe placed between edges and keeps the other bus inputs steady around it. It programs lengths of at least 1 before enabling, so the quiet-while-stopped property only meets an expiry after a real countdown.

// File: rtl/wdt_kp_pkg.sv
package wdt_kp_pkg;
   localparam int OFS_MODE  = 'h00;
   localparam int OFS_LEN   = 'h04;
   localparam int OFS_KICK  = 'h08;
   localparam int OFS_SWRST = 'h14;

   localparam logic [7:0]  KEY_MODE   = 8'h22;
   localparam logic [4:0]  KEY_LEN    = 5'h08;
   localparam logic [31:0] CODE_KICK  = 32'h0000_1971;
   localparam logic [31:0] CODE_SWRST = 32'h0000_1209;

   typedef struct packed {
      logic dual;
      logic auto_go;
      logic irq_mode;
      logic ext_on;
      logic ext_high;
      logic run;
   } mode_t;
endpackage

// File: rtl/wdt_kp_regs.sv
module wdt_kp_regs
   import wdt_kp_pkg::*;
#(
   parameter int ADDR_W = 8,
   parameter int LEN_W  = 11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output mode_t             mode_q,
   output logic [LEN_W-1:0]  len_q,
   output logic              kick_o,
   output logic              swrst_o,
   output logic              start_o
);
   logic mode_ok, len_ok;

   always_comb begin
      mode_ok = bus_wr && (bus_addr == ADDR_W'(OFS_MODE)) && (bus_wdata[31:24] == KEY_MODE);
      len_ok  = bus_wr && (bus_addr == ADDR_W'(OFS_LEN))  && (bus_wdata[4:0] == KEY_LEN);
      kick_o  = bus_wr && (bus_addr == ADDR_W'(OFS_KICK)) && (bus_wdata == CODE_KICK);
      swrst_o = bus_wr && (bus_addr == ADDR_W'(OFS_SWRST)) && (bus_wdata == CODE_SWRST);
      start_o = mode_ok && bus_wdata[0] && !mode_q.run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mode_q <= '0;
         len_q  <= '0;
      end else begin
         if (mode_ok) begin
            mode_q.dual     <= bus_wdata[6];
            mode_q.auto_go  <= bus_wdata[4];
            mode_q.irq_mode <= bus_wdata[3];
            mode_q.ext_on   <= bus_wdata[2];
            mode_q.ext_high <= bus_wdata[1];
            mode_q.run      <= bus_wdata[0];
         end
         if (len_ok) len_q <= bus_wdata[5 +: LEN_W];
      end
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_addr == ADDR_W'(OFS_MODE))
         bus_rdata = {25'b0, mode_q.dual, 1'b0, mode_q.auto_go, mode_q.irq_mode,
                      mode_q.ext_on, mode_q.ext_high, mode_q.run};
      else if (bus_addr == ADDR_W'(OFS_LEN))
         bus_rdata = 32'(len_q) << 5;
   end
endmodule

// File: rtl/wdt_kp_prescale.sv
module wdt_kp_prescale #(
   parameter int DIV_LOG2 = 9
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic clear,
   output logic tick_o
);
   logic [DIV_LOG2-1:0] psc_q;

   assign tick_o = run && (&psc_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     psc_q <= '0;
      else if (clear) psc_q <= '0;
      else if (run)   psc_q <= psc_q + DIV_LOG2'(1);
   end
endmodule

// File: rtl/wdt_kp_core.sv
module wdt_kp_core #(
   parameter int LEN_W    = 11,
   parameter bit HAS_DUAL = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic             irq_mode,
   input  logic             dual,
   input  logic [LEN_W-1:0] len,
   input  logic             kick,
   input  logic             start,
   input  logic             tick,
   output logic             fire_o,
   output logic             rearm_o,
   output logic             irq_o
);
   logic [LEN_W-1:0] cnt_q;
   logic             spent_q;
   logic             dual_on, expire, reload;

   generate
      if (HAS_DUAL) begin : g_dual
         assign dual_on = dual;
      end else begin : g_single
         assign dual_on = 1'b0;
      end
   endgenerate

   always_comb begin
      expire  = run && tick && (cnt_q <= LEN_W'(1)) && !spent_q;
      rearm_o = expire && irq_mode && dual_on && !irq_o;
      fire_o  = expire && (!irq_mode || (dual_on && irq_o));
      reload  = kick || start || rearm_o;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q   <= '0;
         spent_q <= 1'b0;
         irq_o   <= 1'b0;
      end else begin
         if (reload) begin
            cnt_q   <= len;
            spent_q <= 1'b0;
         end else begin
            if (tick && (cnt_q != '0)) cnt_q <= cnt_q - LEN_W'(1);
            if (expire) spent_q <= 1'b1;
         end
         if (kick || start)          irq_o <= 1'b0;
         else if (expire && irq_mode) irq_o <= 1'b1;
      end
   end
endmodule

// File: rtl/wdt_kp_pulse.sv
module wdt_kp_pulse #(
   parameter int PULSE_LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic trig,
   output logic active_o
);
   localparam int CW = $clog2(PULSE_LEN + 1);
   logic [CW-1:0] left_q;

   assign active_o = (left_q != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                left_q <= '0;
      else if (!active_o && trig) left_q <= CW'(PULSE_LEN);
      else if (active_o)         left_q <= left_q - CW'(1);
   end
endmodule

// File: rtl/keyguard_wdt.sv
module keyguard_wdt
   import wdt_kp_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int LEN_W     = 11,
   parameter int DIV_LOG2  = 9,
   parameter int PULSE_LEN = 16,
   parameter bit HAS_DUAL  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [31:0]       bus_wdata,
   output logic [31:0]       bus_rdata,
   output logic              sys_rst_o,
   output logic              ext_rst_o,
   output logic              irq_o
);
   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("keyguard_wdt: ADDR_W must cover offset 0x14");
      end
      if (LEN_W < 1 || LEN_W > 19) begin : g_bad_len
         $error("keyguard_wdt: LEN_W must lie in 1..19");
      end
      if (DIV_LOG2 < 1) begin : g_bad_div
         $error("keyguard_wdt: DIV_LOG2 must be at least 1");
      end
      if (PULSE_LEN < 1) begin : g_bad_pulse
         $error("keyguard_wdt: PULSE_LEN must be at least 1");
      end
   endgenerate

   mode_t            mode_q;
   logic [LEN_W-1:0] len_q;
   logic             kick, swrst, start, tick, fire, rearm;

   wdt_kp_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .mode_q(mode_q),
      .len_q(len_q), .kick_o(kick), .swrst_o(swrst), .start_o(start)
   );

   wdt_kp_prescale #(.DIV_LOG2(DIV_LOG2)) u_psc (
      .clk(clk), .rst_n(rst_n), .run(mode_q.run),
      .clear(kick || start || rearm), .tick_o(tick)
   );

   wdt_kp_core #(.LEN_W(LEN_W), .HAS_DUAL(HAS_DUAL)) u_core (
      .clk(clk), .rst_n(rst_n), .run(mode_q.run), .irq_mode(mode_q.irq_mode),
      .dual(mode_q.dual), .len(len_q), .kick(kick), .start(start),
      .tick(tick), .fire_o(fire), .rearm_o(rearm), .irq_o(irq_o)
   );

   wdt_kp_pulse #(.PULSE_LEN(PULSE_LEN)) u_pulse (
      .clk(clk), .rst_n(rst_n), .trig(fire || swrst), .active_o(sys_rst_o)
   );

   assign ext_rst_o = (mode_q.ext_on & sys_rst_o) ^ ~mode_q.ext_high;
endmodule

// File: rtl/wdt_kp_chk.sv
module wdt_kp_chk
   import wdt_kp_pkg::*;
#(
   parameter int ADDR_W    = 8,
   parameter int LEN_W     = 11,
   parameter int PULSE_LEN = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              bus_wr,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [31:0]       bus_wdata,
   input mode_t             mode_q,
   input logic [LEN_W-1:0]  len_q,
   input logic              sys_rst_o,
   input logic              ext_rst_o,
   input logic              irq_o
);
   localparam int HW = $clog2(PULSE_LEN + 2);
   logic [HW-1:0] hi_cnt;
   logic wr_mode, wr_len, sw_hit, kick_hit, start_hit;

   always_comb begin
      wr_mode   = bus_wr && (bus_addr == ADDR_W'(OFS_MODE));
      wr_len    = bus_wr && (bus_addr == ADDR_W'(OFS_LEN));
      sw_hit    = bus_wr && (bus_addr == ADDR_W'(OFS_SWRST)) && (bus_wdata == CODE_SWRST);
      kick_hit  = bus_wr && (bus_addr == ADDR_W'(OFS_KICK)) && (bus_wdata == CODE_KICK);
      start_hit = wr_mode && (bus_wdata[31:24] == KEY_MODE) && bus_wdata[0] && !mode_q.run;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         hi_cnt <= '0;
      else if (!sys_rst_o) hi_cnt <= '0;
      else if (hi_cnt != '1) hi_cnt <= hi_cnt + HW'(1);
   end

   assert_mode_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_mode && bus_wdata[31:24] != KEY_MODE) |=> $stable(mode_q));

   assert_len_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_len && bus_wdata[4:0] != KEY_LEN) |=> $stable(len_q));

   assert_quiet_stopped_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!mode_q.run && !sys_rst_o && !sw_hit) |=> !sys_rst_o);

   assert_swrst_now_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_hit && !sys_rst_o) |=> sys_rst_o);

   assert_pulse_max_R8: assert property (@(posedge clk) disable iff (!rst_n)
      sys_rst_o |-> (hi_cnt < HW'(PULSE_LEN)));

   assert_pulse_len_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(sys_rst_o) |-> (hi_cnt == HW'(PULSE_LEN)));

   assert_ext_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_q.ext_on |-> (ext_rst_o == !mode_q.ext_high));

   assert_irq_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !kick_hit && !start_hit) |=> irq_o);
endmodule

bind keyguard_wdt wdt_kp_chk #(
   .ADDR_W(ADDR_W), .LEN_W(LEN_W), .PULSE_LEN(PULSE_LEN)
) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
   .bus_wdata(bus_wdata), .mode_q(mode_q), .len_q(len_q),
   .sys_rst_o(sys_rst_o), .ext_rst_o(ext_rst_o), .irq_o(irq_o)
);

// File: tb/keyguard_wdt_test.sv
module keyguard_wdt_test;
   localparam int DIV   = 4;
   localparam int PLEN  = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        sys_rst_o, ext_rst_o, irq_o;
   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   keyguard_wdt #(.ADDR_W(8), .LEN_W(11), .DIV_LOG2(2), .PULSE_LEN(PLEN), .HAS_DUAL(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sys_rst_o(sys_rst_o),
      .ext_rst_o(ext_rst_o), .irq_o(irq_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      rd(8'h00, v); chk("R1 mode", v, 0);
      rd(8'h04, v); chk("R1 length", v, 0);
      chk("R1 sys_rst", sys_rst_o, 0);
      chk("R1 irq", irq_o, 0);
      chk("R1 ext idle", ext_rst_o, 1);
   endtask

   task automatic t_mode_key();
      logic [31:0] v;
      wr(8'h00, 32'h2200_005E);
      rd(8'h00, v); chk("R2 keyed write", v, 32'h5E);
      wr(8'h00, 32'h2100_0001);
      rd(8'h00, v); chk("R2 bad key ignored", v, 32'h5E);
      wr(8'h00, 32'h22FF_FFA0);
      rd(8'h00, v); chk("R2 unused bits", v, 32'h0);
   endtask

   task automatic t_len_key();
      logic [31:0] v;
      wr(8'h04, (32'd5 << 5) | 32'h08);
      rd(8'h04, v); chk("R3 keyed write", v, 32'hA0);
      wr(8'h04, (32'd7 << 5) | 32'h09);
      rd(8'h04, v); chk("R3 bad key ignored", v, 32'hA0);
      wr(8'h04, 32'hFFFF_0000 | (32'd3 << 5) | 32'h08);
      rd(8'h04, v); chk("R3 upper bits ignored", v, 32'h60);
   endtask

   task automatic t_timeout();
      wr(8'h00, 32'h2200_0007);
      idle(3 * DIV - 1);
      chk("R5 before expiry", sys_rst_o, 0);
      idle(1);
      chk("R5 expiry edge", sys_rst_o, 1);
      chk("R9 pin active high", ext_rst_o, 1);
      idle(PLEN - 1);
      chk("R8 pulse last cycle", sys_rst_o, 1);
      idle(1);
      chk("R8 pulse ends", sys_rst_o, 0);
      idle(20);
      chk("R8 no repeat", sys_rst_o, 0);
      wr(8'h00, 32'h2200_0000);
   endtask

   task automatic t_kick();
      wr(8'h00, 32'h2200_0001);
      idle(5);
      wr(8'h08, 32'h0000_1972);
      idle(5);
      chk("R4 wrong code no effect (before)", sys_rst_o, 0);
      idle(1);
      chk("R4 wrong code no effect (expiry)", sys_rst_o, 1);
      idle(10);
      wr(8'h00, 32'h2200_0000);
      wr(8'h00, 32'h2200_0001);
      idle(5);
      wr(8'h08, 32'h0000_1971);
      idle(3 * DIV - 1);
      chk("R4 restart delays expiry", sys_rst_o, 0);
      idle(1);
      chk("R4 expiry after restart", sys_rst_o, 1);
      idle(10);
      wr(8'h00, 32'h2200_0000);
   endtask

   task automatic t_disable();
      wr(8'h00, 32'h2200_0001);
      idle(5);
      wr(8'h00, 32'h2200_0000);
      idle(40);
      chk("R6 stopped no expiry", sys_rst_o, 0);
      wr(8'h00, 32'h2200_0001);
      idle(3 * DIV - 1);
      chk("R6 re-enable full length", sys_rst_o, 0);
      idle(1);
      chk("R6 re-enable expiry", sys_rst_o, 1);
      idle(10);
      wr(8'h00, 32'h2200_0000);
   endtask

   task automatic t_swrst();
      wr(8'h14, 32'h0000_1208);
      chk("R7 wrong code", sys_rst_o, 0);
      idle(3);
      chk("R7 wrong code later", sys_rst_o, 0);
      wr(8'h14, 32'h0000_1209);
      chk("R7 immediate reset", sys_rst_o, 1);
      idle(PLEN);
      chk("R7 pulse done", sys_rst_o, 0);
   endtask

   task automatic t_ext();
      wr(8'h00, 32'h2200_0004);
      chk("R9 low polarity idle", ext_rst_o, 1);
      wr(8'h14, 32'h0000_1209);
      chk("R9 low polarity active", ext_rst_o, 0);
      idle(PLEN);
      chk("R9 low polarity released", ext_rst_o, 1);
      wr(8'h00, 32'h2200_0002);
      chk("R9 pin off idle", ext_rst_o, 0);
      wr(8'h14, 32'h0000_1209);
      chk("R9 pin off during pulse", ext_rst_o, 0);
      chk("R9 internal request", sys_rst_o, 1);
      idle(PLEN);
      wr(8'h00, 32'h2200_0000);
   endtask

   task automatic t_irq();
      wr(8'h04, (32'd2 << 5) | 32'h08);
      wr(8'h00, 32'h2200_0009);
      idle(2 * DIV - 1);
      chk("R10 irq before expiry", irq_o, 0);
      idle(1);
      chk("R10 irq on expiry", irq_o, 1);
      chk("R10 no reset", sys_rst_o, 0);
      idle(20);
      chk("R10 still no reset", sys_rst_o, 0);
      chk("R10 irq sticky", irq_o, 1);
      wr(8'h08, 32'h0000_1971);
      chk("R10 restart clears irq", irq_o, 0);
      wr(8'h00, 32'h2200_0000);
   endtask

   task automatic t_dual();
      wr(8'h00, 32'h2200_0049);
      idle(2 * DIV);
      chk("R11 first expiry irq", irq_o, 1);
      chk("R11 first expiry no reset", sys_rst_o, 0);
      idle(2 * DIV - 1);
      chk("R11 before second expiry", sys_rst_o, 0);
      idle(1);
      chk("R11 second expiry reset", sys_rst_o, 1);
      idle(10);
      wr(8'h00, 32'h2200_0000);
   endtask

   task automatic t_len_late();
      wr(8'h00, 32'h2200_0001);
      idle(2);
      wr(8'h04, (32'd5 << 5) | 32'h08);
      idle(2 * DIV - 4);
      chk("R12 old length before", sys_rst_o, 0);
      idle(1);
      chk("R12 old length kept", sys_rst_o, 1);
      idle(10);
      wr(8'h00, 32'h2200_0000);
      wr(8'h00, 32'h2200_0001);
      idle(5 * DIV - 1);
      chk("R12 new length before", sys_rst_o, 0);
      idle(1);
      chk("R12 new length applied", sys_rst_o, 1);
      idle(10);
      wr(8'h00, 32'h2200_0000);
   endtask

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_mode_key();
      t_len_key();
      t_timeout();
      t_kick();
      t_disable();
      t_swrst();
      t_ext();
      t_irq();
      t_dual();
      t_len_late();
      if (!done) begin
         done = 1'b1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog expired actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule